// File: doc/BRIEF.md
# Thermal Protection Register Block

This block holds the software-visible control and status state of a thermal protection path. Temperature sensing and comparison happen elsewhere. The block sees a single-cycle pulse for each rising or falling trip event and a level for a catastrophic trip. It also receives a live zone-state vector that it passes through unchanged.

Software reaches the block through a flat register port. A write takes effect on the clock edge, and read data follows the address combinationally. Four registers are decoded:

| Address | Register |
|---|---|
| 0 | control, in read bits 7:0 |
| 1 | latched event status |
| 2 | live zone state, zero-extended |
| 3 | zero |

The control register has two active bits:
- A halt-on-catastrophic enable.
- A self-locking bit that freezes the whole register until reset.

Latched status is write-1-to-clear. It is kept apart from the live zone state, so an event that arrives after software has read the status is never lost. The interrupt output is the OR of the latched status. The clock-enable output drops for good once a catastrophic trip is seen while halting is enabled.

Top module: `thermguard_regs`

## Requirements
- R1: While `rst_n` is low at a clock edge, control and status clear to 0. After that edge `irq` is 0 and `clk_en` is 1.
- R2: A write to address 0 while unlocked stores bit 3 (halt enable) and bit 0 (lock) from `reg_wdata` on the next edge. Control bits 7:4 and 2:1 always read 0.
- R3: Once control bit 0 is 1, every write to address 0 is ignored until reset. This includes writes that try to clear the lock. Lock and halt enable may be set in the same write.
- R4: At each edge, `trip_rise` sets status bit 0, `trip_fall` sets status bit 1, and `trip_cat` sets status bit 2. Status bits 15:3 always read 0.
- R5: A write to address 1 clears each status bit whose `reg_wdata` bit is 1. Bits written with 0 are unchanged.
- R6: If an event sets a status bit in the same cycle that software writes 1 to clear it, the bit ends at 1.
- R7: `irq` is 1 exactly while at least one latched status bit is 1.
- R8: `trip_cat` high at an edge while control bit 3 is 1 drives `clk_en` to 0 after that edge. With control bit 3 at 0, `clk_en` stays 1.
- R9: Once `clk_en` is 0 it stays 0 until reset, whatever software writes.
- R10: Address 2 reads the current `zone_live` value, independent of latched status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| trip_rise | input | 1 | Rising-trip event pulse |
| trip_fall | input | 1 | Falling-trip event pulse |
| trip_cat | input | 1 | Catastrophic trip |
| zone_live | input | 4 | Live zone state |
| irq | output | 1 | Interrupt request |
| clk_en | output | 1 | Clock enable for the halt path |

## Verification
The assertions assume the following about the inputs:
- Inputs are stable around the clock edge.
- Control only moves through the write strobe.
- The one-cycle look-back after reset is meaningful only once reset has been released.

The stimulus honours this by changing inputs just after each rising edge. It holds reset for several cycles and mixes event pulses with writes. This includes deliberate same-cycle set/clear collisions and writes issued after the lock or the halt has taken hold.

// File: rtl/thg_pkg.sv
// Package: shared widths, register addresses and bit positions for the
// thermal protection register block. Assumes a 2-bit register address.
package thg_pkg;
    localparam int CTRL_W  = 8;
    localparam int STAT_W  = 16;
    localparam int ADDR_W  = 2;

    localparam int CTRL_LOCK_BIT = 0;
    localparam int CTRL_HALT_BIT = 3;
    localparam logic [CTRL_W-1:0] CTRL_WMASK =
        CTRL_W'((1 << CTRL_LOCK_BIT) | (1 << CTRL_HALT_BIT));

    localparam int EVT_RISE = 0;
    localparam int EVT_FALL = 1;
    localparam int EVT_CAT  = 2;
    localparam int EVT_N    = 3;

    typedef enum logic [ADDR_W-1:0] {
        ADR_CTRL = 2'd0,
        ADR_STAT = 2'd1,
        ADR_ZONE = 2'd2,
        ADR_NONE = 2'd3
    } reg_adr_e;
endpackage

// File: rtl/thg_ctrl_reg.sv
// Module: control register with a self-locking bit.
// Only bits in WMASK are stored; the others stay 0. Once the lock bit is 1,
// writes are ignored until the synchronous active-low reset.
// Assumes wr_en is a single-cycle qualified write strobe.
module thg_ctrl_reg #(
    parameter int W        = 8,
    parameter int LOCK_BIT = 0,
    parameter logic [W-1:0] WMASK = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] ctrl_q
);
    logic locked;
    assign locked = ctrl_q[LOCK_BIT];

    // Store the writable bits unless the register has locked itself.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (wr_en && !locked)
            ctrl_q <= wdata & WMASK;
    end

    // R3
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> (ctrl_q == $past(ctrl_q)));
    // R2
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !locked) |=> ((ctrl_q & ~WMASK) == '0));
endmodule

// File: rtl/thg_status_reg.sv
// Module: latched event status, write-1-to-clear, one generated cell per bit.
// A set input in the same cycle as a clear wins, so no event is lost.
// Assumes set_vec bits are sampled as levels at each edge.
module thg_status_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_en,
    input  logic [W-1:0] clr_mask,
    input  logic [W-1:0] set_vec,
    output logic [W-1:0] stat_q,
    output logic         any_set
);
    for (genvar b = 0; b < W; b++) begin : g_cell
        // Per-bit latch: set dominates, otherwise clear on a written 1.
        always_ff @(posedge clk) begin
            if (!rst_n)
                stat_q[b] <= 1'b0;
            else if (set_vec[b])
                stat_q[b] <= 1'b1;
            else if (clr_en && clr_mask[b])
                stat_q[b] <= 1'b0;
        end
    end

    // Summary flag for the interrupt.
    always_comb any_set = |stat_q;

    // R6
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((stat_q & $past(set_vec)) == $past(set_vec)));
    // R5
    w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> ((stat_q & $past(clr_mask & ~set_vec)) == '0));
endmodule

// File: rtl/thg_halt.sv
// Module: sticky clock-halt latch. A catastrophic trip seen while halting is
// enabled drops clk_en on the next edge; only reset raises it again.
module thg_halt (
    input  logic clk,
    input  logic rst_n,
    input  logic cat_trip,
    input  logic halt_en,
    output logic clk_en
);
    logic halted;

    // Latch the halt condition until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            halted <= 1'b0;
        else if (cat_trip && halt_en)
            halted <= 1'b1;
    end

    // Drive the enable from the latch.
    always_comb clk_en = ~halted;

    // R8
    halt_on_cat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cat_trip && halt_en) |=> !clk_en);
    // R9
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> !clk_en);
endmodule

// File: rtl/thermguard_regs.sv
// Module: top of the thermal protection register block. It decodes the
// register port, routes trip events into status, and exposes irq and clk_en.
// Assumes trip_rise/trip_fall are pulses and trip_cat is a level.
module thermguard_regs
    import thg_pkg::*;
#(
    parameter int ZONE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [STAT_W-1:0] reg_wdata,
    output logic [STAT_W-1:0] reg_rdata,
    input  logic              trip_rise,
    input  logic              trip_fall,
    input  logic              trip_cat,
    input  logic [ZONE_W-1:0] zone_live,
    output logic              irq,
    output logic              clk_en
);
    logic [CTRL_W-1:0] ctrl_q;
    logic [STAT_W-1:0] stat_q;
    logic [STAT_W-1:0] set_vec;
    logic              ctrl_wr, stat_wr, any_set;

    // Address decode for writes.
    always_comb begin
        ctrl_wr = reg_wr && (reg_addr == ADR_CTRL);
        stat_wr = reg_wr && (reg_addr == ADR_STAT);
    end

    // Map trip inputs onto their status bits.
    always_comb begin
        set_vec = '0;
        set_vec[EVT_RISE] = trip_rise;
        set_vec[EVT_FALL] = trip_fall;
        set_vec[EVT_CAT]  = trip_cat;
    end

    thg_ctrl_reg #(.W(CTRL_W), .LOCK_BIT(CTRL_LOCK_BIT), .WMASK(CTRL_WMASK)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(ctrl_wr),
        .wdata(reg_wdata[CTRL_W-1:0]), .ctrl_q(ctrl_q)
    );

    thg_status_reg #(.W(STAT_W)) u_stat (
        .clk(clk), .rst_n(rst_n), .clr_en(stat_wr), .clr_mask(reg_wdata),
        .set_vec(set_vec), .stat_q(stat_q), .any_set(any_set)
    );

    thg_halt u_halt (
        .clk(clk), .rst_n(rst_n), .cat_trip(trip_cat),
        .halt_en(ctrl_q[CTRL_HALT_BIT]), .clk_en(clk_en)
    );

    // Interrupt follows the latched status.
    always_comb irq = any_set;

    // Read mux.
    always_comb begin
        unique case (reg_adr_e'(reg_addr))
            ADR_CTRL: reg_rdata = STAT_W'(ctrl_q);
            ADR_STAT: reg_rdata = stat_q;
            ADR_ZONE: reg_rdata = STAT_W'(zone_live);
            default:  reg_rdata = '0;
        endcase
    end

    // R4
    unused_stat_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADR_STAT) |-> (reg_rdata[STAT_W-1:EVT_N] == '0));
    // R7
    irq_tracks_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADR_STAT) |-> (irq == (reg_rdata != '0)));
endmodule

// File: tb/thermguard_regs_tb_top.sv
// Bench: behavioural reference model updated each rising edge and compared
// with the design at every falling edge, plus directed checks per requirement.
module thermguard_regs_tb_top;
    logic        clk = 0, rst_n = 0, reg_wr = 0;
    logic [1:0]  reg_addr = 0;
    logic [15:0] reg_wdata = 0, reg_rdata;
    logic        trip_rise = 0, trip_fall = 0, trip_cat = 0;
    logic [3:0]  zone_live = 0;
    logic        irq, clk_en;

    int total = 0, bad = 0;
    int m_ctrl = 0, m_stat = 0, m_halt = 0;
    bit done = 0;

    thermguard_regs dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .trip_rise(trip_rise),
        .trip_fall(trip_fall), .trip_cat(trip_cat), .zone_live(zone_live),
        .irq(irq), .clk_en(clk_en)
    );

    always #2.5 clk = ~clk;

    // Reference model, written from the requirements.
    always @(posedge clk) begin
        int old_ctrl, clr, setv;
        old_ctrl = m_ctrl;
        if (!rst_n) begin
            m_ctrl = 0; m_stat = 0; m_halt = 0;
        end else begin
            if (reg_wr && reg_addr == 0 && (old_ctrl & 1) == 0)
                m_ctrl = reg_wdata & 'h09;
            clr  = (reg_wr && reg_addr == 1) ? int'(reg_wdata) : 0;
            setv = {trip_cat, trip_fall, trip_rise};
            m_stat = (m_stat & ~clr) | setv;
            if (trip_cat && (old_ctrl & 8) != 0) m_halt = 1;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int exp_rd();
        case (reg_addr)
            2'd0: return m_ctrl;
            2'd1: return m_stat;
            2'd2: return int'(zone_live);
            default: return 0;
        endcase
    endfunction

    // Per-cycle comparison away from the active edge.
    always @(negedge clk) if (rst_n && !done) begin
        chk("R7 irq", int'(irq), int'(m_stat != 0));
        chk("R8 clk_en", int'(clk_en), int'(m_halt == 0));
        chk(reg_addr == 0 ? "R2 ctrl read" : reg_addr == 1 ? "R5 status read" :
            reg_addr == 2 ? "R10 zone read" : "R4 empty read", int'(reg_rdata), exp_rd());
    end

    task automatic tick();
        @(posedge clk); #1;
        reg_wr = 0; trip_rise = 0; trip_fall = 0; trip_cat = 0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d; tick();
    endtask

    task automatic rd_at(input logic [1:0] a, input string tag, input int exp);
        reg_addr = a; #0.5; chk(tag, int'(reg_rdata), exp);
    endtask

    task automatic do_reset();
        rst_n = 0; repeat (3) tick(); rst_n = 1;
    endtask

    initial begin
        #200000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int lf;
        do_reset();
        // R1: reset state
        rd_at(0, "R1 ctrl", 0); rd_at(1, "R1 stat", 0);
        chk("R1 irq", int'(irq), 0); chk("R1 clk_en", int'(clk_en), 1);
        // R2: only bits 3 and 0 stored; here write without lock
        wr(0, 16'h00F6); rd_at(0, "R2 masked write", 'h00);
        wr(0, 16'h00FE); rd_at(0, "R2 halt bit", 'h08);
        // R4: event mapping
        trip_rise = 1; tick(); rd_at(1, "R4 rise bit0", 'h1);
        trip_fall = 1; tick(); rd_at(1, "R4 fall bit1", 'h3);
        // R5: write-1-to-clear, zero leaves bits
        wr(1, 16'h0000); rd_at(1, "R5 zero write", 'h3);
        wr(1, 16'h0001); rd_at(1, "R5 clear bit0", 'h2);
        // R6: set wins over clear
        trip_fall = 1; wr(1, 16'hFFFF); rd_at(1, "R6 set wins", 'h2);
        wr(1, 16'hFFFF); rd_at(1, "R7 cleared", 0); chk("R7 irq low", int'(irq), 0);
        // R10: live zone independent of status
        zone_live = 4'hA; rd_at(2, "R10 zone A", 'hA);
        zone_live = 4'h5; rd_at(2, "R10 zone 5", 'h5); rd_at(1, "R10 stat untouched", 0);
        // R8/R9: halt with enable, sticky through writes
        trip_cat = 1; tick(); chk("R8 halted", int'(clk_en), 0);
        rd_at(1, "R4 cat bit2", 'h4);
        wr(0, 16'h0000); wr(1, 16'hFFFF); tick();
        chk("R9 still halted", int'(clk_en), 0);
        do_reset(); chk("R9 reset releases", int'(clk_en), 1);
        // R3: lock with halt clear, then try to change
        wr(0, 16'h0001); rd_at(0, "R3 locked", 'h01);
        wr(0, 16'h0008); rd_at(0, "R3 write ignored", 'h01);
        wr(0, 16'h0000); rd_at(0, "R3 unlock ignored", 'h01);
        trip_cat = 1; tick(); chk("R8 no halt when disabled", int'(clk_en), 1);
        do_reset();
        wr(0, 16'h0009); rd_at(0, "R3 lock and halt together", 'h09);
        do_reset();
        // Mixed stimulus, checked each cycle against the model.
        lf = 32'h1ACE;
        for (int i = 0; i < 400; i++) begin
            lf = (lf << 1) ^ ((lf >>> 31) & 1 ? 32'h04C11DB7 : 0);
            reg_addr = lf[3:2]; reg_wdata = 16'(lf >> 8);
            reg_wr = (lf[6:4] == 3'd0); trip_rise = lf[10];
            trip_fall = lf[13] & lf[14]; trip_cat = (lf[20:16] == 5'd3);
            zone_live = lf[27:24];
            if (i == 200) do_reset();
            @(posedge clk); #1;
        end
        reg_wr = 0; trip_rise = 0; trip_fall = 0; trip_cat = 0;
        tick();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule